// File: doc/BRIEF.md
# Sleep-Capable Weighted Threshold Gate

This block models one threshold gate for a dual-rail, return-to-NULL datapath. Each input is a single rail of some dual-rail signal. Each input carries a weight that is fixed at compile time. When the sum of the weights of the asserted inputs reaches the threshold, the gate output goes to DATA (high). The output then holds high through hysteresis, and falls back to NULL (low) only once every input has dropped.

A sleep input clears the held state and keeps the output at NULL for as long as it is high. A build parameter removes the sleep path, which gives a plain hysteresis gate that ignores the pin. The state element is a clocked register with an asynchronous active-low reset. Every output decision therefore shows up one clock edge after the inputs that cause it.

Top module: `ncl_thresh_gate`

## Requirements
- R1: While rst_n is low, dout is 0, and it stays 0 on the first edge after release if no input is asserted.
- R2: Input i has the weight held in bits [4*i+3:4*i] of IN_WEIGHTS. By default that is din[0]=2, din[1]=1 and din[2]=1, with threshold 2. When the weighted sum of the asserted inputs is at least the threshold and sleep is inactive, dout is 1 after the next clock edge.
- R3: From the NULL state, a weighted sum below the threshold leaves dout at 0. By default, din[1] alone or din[2] alone does not assert the gate.
- R4: Several inputs of weight 1 together can reach the threshold. By default, din[1] and din[2] together assert dout.
- R5: Once dout is 1, it stays 1 while at least one input is still asserted, even if the weighted sum has fallen below the threshold.
- R6: Once dout is 1, it returns to 0 on the edge after all inputs are 0.
- R7: With USE_SLEEP=1, sleep high forces dout to 0 on the next edge and holds it there, whatever the inputs are.
- R8: After sleep is released, the gate starts from the NULL state. dout stays 0 while the weighted sum is below the threshold, even if some inputs are asserted, and it rises on the first edge at which the threshold is met.
- R9: With USE_SLEEP=0, the sleep input has no effect on dout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state element |
| rst_n | input | 1 | Asynchronous active-low reset; the gate powers up in NULL |
| sleep | input | 1 | Forces NULL while high; ignored when USE_SLEEP=0 |
| din | input | N_IN | Single-rail inputs, weighted by IN_WEIGHTS |
| dout | output | 1 | Gate output: 1 is DATA, 0 is NULL |

## Verification
The gate keeps a single bit of state. A wrong value in that bit can only be seen in cycles where the inputs neither meet the threshold nor are all NULL. In those cycles the output is decided by what was held before. For that reason the stimulus keeps partial input sets applied right after assertion, right after release, and right after sleep ends. A lost or stuck hold bit then shows at dout one edge later. The vector walk also compares one instance with sleep against one without, on the same inputs, so a sleep path that leaks into the sleep-free build shows up as a mismatch.

// File: rtl/ncl_thr_pkg.sv
package ncl_thr_pkg;
  localparam int unsigned WEIGHT_W = 4;

  typedef enum logic {
    GATE_NULL = 1'b0,
    GATE_DATA = 1'b1
  } gate_state_e;
endpackage

// File: rtl/ncl_weight_sum.sv
module ncl_weight_sum #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned SUM_W = 6,
  parameter logic [N_IN*ncl_thr_pkg::WEIGHT_W-1:0] IN_WEIGHTS = '0
) (
  input  logic [N_IN-1:0]  din,
  output logic [SUM_W-1:0] wsum
);
  localparam int unsigned WW = ncl_thr_pkg::WEIGHT_W;

  logic [SUM_W-1:0] term [N_IN];

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_term
      assign term[gi] = din[gi] ? SUM_W'(IN_WEIGHTS[gi*WW +: WW]) : '0;
    end
  endgenerate

  always_comb begin
    wsum = '0;
    for (int k = 0; k < N_IN; k++) begin
      wsum = wsum + term[k];
    end
  end
endmodule

// File: rtl/ncl_thresh_cmp.sv
module ncl_thresh_cmp #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned SUM_W  = 6,
  parameter int unsigned THRESH = 2
) (
  input  logic [N_IN-1:0]  din,
  input  logic [SUM_W-1:0] wsum,
  output logic             set_hit,
  output logic             all_null
);
  localparam logic [SUM_W-1:0] THR_V = SUM_W'(THRESH);

  assign set_hit  = (wsum >= THR_V);
  assign all_null = (din == '0);
endmodule

// File: rtl/ncl_hold_reg.sv
module ncl_hold_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_eff,
  input  logic set_hit,
  input  logic all_null,
  output logic q
);
  import ncl_thr_pkg::*;

  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_NULL: if (!sleep_eff && set_hit) state_d = GATE_DATA;
      GATE_DATA: if (sleep_eff || all_null) state_d = GATE_NULL;
      default:   state_d = GATE_NULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GATE_NULL;
    else        state_q <= state_d;
  end

  assign q = (state_q == GATE_DATA);
endmodule

// File: rtl/ncl_thresh_gate.sv
module ncl_thresh_gate #(
  parameter int unsigned N_IN      = 3,
  parameter int unsigned THRESH    = 2,
  parameter bit          USE_SLEEP = 1'b1,
  parameter logic [N_IN*ncl_thr_pkg::WEIGHT_W-1:0] IN_WEIGHTS = {4'd1, 4'd1, 4'd2}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep,
  input  logic [N_IN-1:0] din,
  output logic            dout
);
  localparam int unsigned SUM_W    = ncl_thr_pkg::WEIGHT_W + $clog2(N_IN + 1);
  localparam logic        SLEEP_EN = USE_SLEEP;

  logic [SUM_W-1:0] wsum;
  logic set_hit, all_null, sleep_eff;

  assign sleep_eff = sleep & SLEEP_EN;

  ncl_weight_sum #(.N_IN(N_IN), .SUM_W(SUM_W), .IN_WEIGHTS(IN_WEIGHTS)) u_sum (
    .din(din), .wsum(wsum)
  );

  ncl_thresh_cmp #(.N_IN(N_IN), .SUM_W(SUM_W), .THRESH(THRESH)) u_cmp (
    .din(din), .wsum(wsum), .set_hit(set_hit), .all_null(all_null)
  );

  ncl_hold_reg u_hold (
    .clk(clk), .rst_n(rst_n), .sleep_eff(sleep_eff),
    .set_hit(set_hit), .all_null(all_null), .q(dout)
  );

  p_threshold_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !sleep_eff) |=> dout);

  p_rise_needs_threshold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> $past(set_hit));

  p_hysteresis_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout && !sleep_eff && din != '0) |=> dout);

  p_null_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (din == '0) |=> !dout);

  generate
    if (USE_SLEEP) begin : g_sleep_chk
      p_sleep_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !dout);
    end else begin : g_nosleep_chk
      p_sleep_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout && din != '0) |=> dout);
    end
  endgenerate
endmodule

// File: tb/ncl_thresh_gate_bench.sv
module ncl_thresh_gate_bench;
  logic clk, rst_n, sleep;
  logic [2:0] din;
  logic dout, dout_ns;
  int checks = 0, errors = 0;
  bit done = 0;

  ncl_thresh_gate u_ncl_thresh_gate (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .din(din), .dout(dout)
  );

  ncl_thresh_gate #(.USE_SLEEP(1'b0)) u_ncl_thresh_gate_nosleep (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .din(din), .dout(dout_ns)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // entry bits: {sleep, din[2:0], expected dout (sleep build), expected dout (sleep-free build)}
  localparam int NV = 16;
  localparam logic [5:0] VEC [NV] = '{
    6'b0_000_0_0,  // R1 idle after reset
    6'b0_010_0_0,  // R3 din[1] alone
    6'b0_100_0_0,  // R3 din[2] alone
    6'b0_001_1_1,  // R2 din[0] weight 2
    6'b0_011_1_1,  // R2
    6'b0_010_1_1,  // R5 hold below threshold
    6'b0_000_0_0,  // R6 release
    6'b0_110_1_1,  // R4 two unit weights
    6'b0_100_1_1,  // R5
    6'b1_100_0_1,  // R7 / R9
    6'b1_111_0_1,  // R7 / R9
    6'b0_100_0_1,  // R8 partial after wake stays low
    6'b0_101_1_1,  // R8 rises when threshold met
    6'b0_000_0_0,  // R6
    6'b1_001_0_1,  // R7 / R9
    6'b0_000_0_0   // R6
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected %b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sleep = 0; din = 3'b001;
    repeat (3) @(posedge clk);
    #1;
    check(dout, 1'b0, "R1 in reset");
    check(dout_ns, 1'b0, "R1 in reset nosleep");
    @(negedge clk);
    din = 3'b000; rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sleep = VEC[i][5];
      din   = VEC[i][4:2];
      @(posedge clk); #1;
      check(dout,    VEC[i][1], $sformatf("R2-R8 vector %0d sleep build", i));
      check(dout_ns, VEC[i][0], $sformatf("R9 vector %0d sleep-free build", i));
    end

    // R1: reset mid-run clears a held DATA
    @(negedge clk); din = 3'b001; sleep = 0;
    @(posedge clk); #1;
    check(dout, 1'b1, "R2 before reset");
    @(negedge clk); rst_n = 0;
    #1;
    check(dout, 1'b0, "R1 async reset");
    check(dout_ns, 1'b0, "R1 async reset nosleep");
    @(negedge clk); din = 3'b010; rst_n = 1;
    @(posedge clk); #1;
    check(dout, 1'b0, "R3 partial after reset");

    // R6: release needs every input low, not just threshold loss
    @(negedge clk); din = 3'b110;
    @(posedge clk); #1;
    check(dout, 1'b1, "R4 pair asserts");
    @(negedge clk); din = 3'b100;
    @(posedge clk); #1;
    check(dout, 1'b1, "R5 single still held");
    @(negedge clk); din = 3'b000;
    @(posedge clk); #1;
    check(dout, 1'b0, "R6 all NULL releases");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule